// File: doc/BRIEF.md
# Eight-Bit Timer Counter Core

This block is the counting heart of an 8-bit timer. On every cycle where the prescaler supplies a tick and the clock-select field is non-zero, the count register is cleared, incremented or decremented according to one of four counting modes. It drives a set of indicator outputs for the waveform and compare logic that sits beside it: a strobe while the count holds its largest value, a strobe while it holds zero, and a sticky overflow flag that can raise an interrupt request.

A processor port can load the count at any time, including while the timer is stopped. Such a load always wins over whatever the counting logic would have done in that cycle. A one-cycle pulse marks each load so that a neighbouring compare unit can suppress the match that would otherwise follow it.

Top module: `tmr8_core`

## Requirements
- R1: After a synchronous reset the count is 0x00, the bottom strobe is 1, and the max strobe, overflow flag, interrupt request and load pulse are all 0. Phase-correct counting starts upward.
- R2: While `clk_sel` is 0 the count does not change, whatever `tick_en` does. Any other `clk_sel` value lets each `tick_en` cycle advance the counter.
- R3: In normal mode (`mode` = 0) each tick adds one, and 0xFF goes to 0x00. A tick taken at 0xFF sets the overflow flag.
- R4: In clear-on-compare mode (`mode` = 1) a tick taken while the count equals `cmp_val` loads 0x00; other ticks add one. A tick at 0xFF sets the overflow flag.
- R5: In fast PWM mode (`mode` = 2) the count runs 0x00 to 0xFF and wraps, and the flag is set by the tick taken at 0xFF.
- R6: In phase-correct mode (`mode` = 3) the count rises to 0xFF, then falls to 0x00, then rises again, so 0xFF and 0x00 each appear once per turn. The flag is set by the falling tick that reaches 0x00. Any other mode forces the direction back to upward.
- R7: A cycle with `cnt_wr` high loads `cnt_wdata` into the count, visible on the next cycle. This replaces any clear, increment or decrement, and the suppressed tick sets no flag. The direction is unchanged.
- R8: Loads through `cnt_wr` work the same while the timer is stopped (`clk_sel` = 0).
- R9: `at_max` is 1 exactly when the count is 0xFF, and `at_bottom` is 1 exactly when the count is 0x00, in every cycle.
- R10: The overflow flag is cleared by `ovf_clr` (write-one-to-clear) or by `ovf_ack`. If a setting event falls in the same cycle, setting wins.
- R11: `ovf_irq` equals the overflow flag ANDed with `ovf_ie`, in the same cycle.
- R12: `cnt_wr_pulse` is high for exactly the one cycle after each `cnt_wr` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled timer tick enable |
| clk_sel | input | 3 | Clock select; 0 stops the counter |
| mode | input | 2 | Counting mode: 0 normal, 1 clear-on-compare, 2 fast PWM, 3 phase-correct |
| cmp_val | input | 8 | Compare value used by clear-on-compare |
| cnt_wr | input | 1 | Processor load strobe for the count |
| cnt_wdata | input | 8 | Value to load |
| ovf_clr | input | 1 | Write-one-to-clear of the overflow flag |
| ovf_ack | input | 1 | Interrupt acknowledge; clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | 8 | Current count |
| at_max | output | 1 | Count equals 0xFF |
| at_bottom | output | 1 | Count equals 0x00 |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cnt_wr_pulse | output | 1 | One-cycle marker following a count load |

## Verification
The count, the two strobes, the overflow flag and the load pulse come from registers, so each reflects the inputs of a cycle one clock edge later. `ovf_irq` follows the flag and `ovf_ie` in the same cycle. The bench drives inputs on the falling edge and steps a reference model after each rising edge, using the inputs that were present at that edge. It then compares every output one nanosecond after the edge, which puts each registered result in the cycle it is due. Random runs over modes, clock selects, loads and clears are mixed with directed wrap, turnaround, load-priority and set-versus-clear cases.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_CLRCMP = 2'd1,
    MODE_FPWM  = 2'd2,
    MODE_PCPWM = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr8_tick_gate.sv
module tmr8_tick_gate #(
  parameter int CSEL_W = 3
) (
  input  logic              tick_en,
  input  logic [CSEL_W-1:0] clk_sel,
  output logic              step
);
  // A zero select stops the timer; any other source passes the prescaled tick.
  assign step = tick_en && (clk_sel != '0);
endmodule

// File: rtl/tmr8_count_seq.sv
module tmr8_count_seq
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [1:0]   mode,
  input  logic [W-1:0] cmp_val,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic         at_max,
  output logic         at_bottom,
  output logic         ovf_evt
);
  localparam logic [W-1:0] TOPV = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  tmr_mode_e   md;
  logic        down_q, down_n;
  logic [W-1:0] cnt_n;

  assign md = tmr_mode_e'(mode);

  always_comb begin
    cnt_n   = count;
    down_n  = down_q;
    ovf_evt = 1'b0;
    if (wr) begin
      cnt_n = wdata;
    end else if (step) begin
      unique case (md)
        MODE_CLRCMP: begin
          cnt_n   = (count == cmp_val) ? ZERO : count + ONE;
          ovf_evt = (count == TOPV);
        end
        MODE_PCPWM: begin
          if (!down_q) begin
            if (count == TOPV) begin
              cnt_n  = count - ONE;
              down_n = 1'b1;
            end else begin
              cnt_n = count + ONE;
            end
          end else begin
            if (count == ZERO) begin
              cnt_n  = ONE;
              down_n = 1'b0;
            end else begin
              cnt_n   = count - ONE;
              ovf_evt = (count == ONE);
            end
          end
        end
        default: begin
          cnt_n   = count + ONE;
          ovf_evt = (count == TOPV);
        end
      endcase
    end
    if (md != MODE_PCPWM) down_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= ZERO;
      down_q    <= 1'b0;
      at_max    <= 1'b0;
      at_bottom <= 1'b1;
    end else begin
      count     <= cnt_n;
      down_q    <= down_n;
      at_max    <= (cnt_n == TOPV);
      at_bottom <= (cnt_n == ZERO);
    end
  end

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    wr |=> (count == $past(wdata)));
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr) |=> $stable(count));
  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (rst)
    (step && !wr && mode == 2'd1 && count == cmp_val) |=> (count == ZERO));
  a_r9_strobe_max: assert property (@(posedge clk) disable iff (rst)
    at_max == (count == TOPV));
  a_r9_strobe_bottom: assert property (@(posedge clk) disable iff (rst)
    at_bottom == (count == ZERO));
endmodule

// File: rtl/tmr8_ovf_flag.sv
module tmr8_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)                  flag <= 1'b0;
    else if (set_i)           flag <= 1'b1;
    else if (clr_i || ack_i)  flag <= 1'b0;
  end

  assign irq = flag && ie;

  a_r3_flag_sets: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag);
  a_r10_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (!set_i && (clr_i || ack_i)) |=> !flag);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i && !ack_i) |=> $stable(flag));
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int W      = 8,
  parameter int CSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CSEL_W-1:0] clk_sel,
  input  logic [1:0]        mode,
  input  logic [W-1:0]      cmp_val,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wdata,
  input  logic              ovf_clr,
  input  logic              ovf_ack,
  input  logic              ovf_ie,
  output logic [W-1:0]      count,
  output logic              at_max,
  output logic              at_bottom,
  output logic              ovf_flag,
  output logic              ovf_irq,
  output logic              cnt_wr_pulse
);
  logic step;
  logic ovf_evt;

  tmr8_tick_gate #(.CSEL_W(CSEL_W)) u_gate (
    .tick_en(tick_en), .clk_sel(clk_sel), .step(step)
  );

  tmr8_count_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .step(step), .mode(mode), .cmp_val(cmp_val),
    .wr(cnt_wr), .wdata(cnt_wdata), .count(count), .at_max(at_max),
    .at_bottom(at_bottom), .ovf_evt(ovf_evt)
  );

  tmr8_ovf_flag u_ovf (
    .clk(clk), .rst(rst), .set_i(ovf_evt), .clr_i(ovf_clr), .ack_i(ovf_ack),
    .ie(ovf_ie), .flag(ovf_flag), .irq(ovf_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) cnt_wr_pulse <= 1'b0;
    else     cnt_wr_pulse <= cnt_wr;
  end

  a_r12_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_wr_pulse);
  a_r12_pulse_single: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> !cnt_wr_pulse);
  a_r2_stopped_no_flag: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == '0 && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/tmr8_core_test.sv
`timescale 1ns/1ps
module tmr8_core_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en;
  logic [2:0] clk_sel;
  logic [1:0] mode;
  logic [7:0] cmp_val;
  logic       cnt_wr;
  logic [7:0] cnt_wdata;
  logic       ovf_clr, ovf_ack, ovf_ie;
  logic [7:0] count;
  logic       at_max, at_bottom, ovf_flag, ovf_irq, cnt_wr_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [7:0] m_cnt;
  bit         m_down, m_flag, m_pulse;

  always #2 clk = ~clk;

  tmr8_core uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clk_sel(clk_sel), .mode(mode),
    .cmp_val(cmp_val), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ovf_clr(ovf_clr), .ovf_ack(ovf_ack), .ovf_ie(ovf_ie), .count(count),
    .at_max(at_max), .at_bottom(at_bottom), .ovf_flag(ovf_flag),
    .ovf_irq(ovf_irq), .cnt_wr_pulse(cnt_wr_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] md);
    case (md)
      2'd0: return "R3 normal count";
      2'd1: return "R4 clear-on-compare count";
      2'd2: return "R5 fast PWM count";
      default: return "R6 phase-correct count";
    endcase
  endfunction

  // Reference step, written from R2..R7, R10, R12.
  task automatic model_step();
    bit st, set_evt;
    logic [7:0] nc;
    bit nd;
    st = tick_en && (clk_sel != 3'd0);
    set_evt = 1'b0;
    nc = m_cnt;
    nd = m_down;
    if (cnt_wr) nc = cnt_wdata;
    else if (st) begin
      if (mode == 2'd3) begin
        if (!m_down) begin
          if (m_cnt == 8'hFF) begin nc = 8'hFE; nd = 1'b1; end
          else nc = m_cnt + 8'd1;
        end else begin
          if (m_cnt == 8'h00) begin nc = 8'h01; nd = 1'b0; end
          else begin nc = m_cnt - 8'd1; set_evt = (m_cnt == 8'h01); end
        end
      end else if (mode == 2'd1) begin
        nc = (m_cnt == cmp_val) ? 8'h00 : m_cnt + 8'd1;
        set_evt = (m_cnt == 8'hFF);
      end else begin
        nc = m_cnt + 8'd1;
        set_evt = (m_cnt == 8'hFF);
      end
    end
    if (mode != 2'd3) nd = 1'b0;
    m_cnt = nc;
    m_down = nd;
    if (set_evt) m_flag = 1'b1;
    else if (ovf_clr || ovf_ack) m_flag = 1'b0;
    m_pulse = cnt_wr;
  endtask

  task automatic compare_all();
    chk(mode_req(mode), count, m_cnt);
    chk("R9 max strobe", at_max, (m_cnt == 8'hFF));
    chk("R9 bottom strobe", at_bottom, (m_cnt == 8'h00));
    chk("R10 overflow flag", ovf_flag, m_flag);
    chk("R11 irq", ovf_irq, m_flag && ovf_ie);
    chk("R12 load pulse", cnt_wr_pulse, m_pulse);
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic cycle();
    @(posedge clk);
    #1;
    model_step();
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cnt_wr = 0; ovf_clr = 0; ovf_ack = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; tick_en = 0; clk_sel = 0; mode = 0; cmp_val = 8'h10;
    cnt_wr = 0; cnt_wdata = 0; ovf_clr = 0; ovf_ack = 0; ovf_ie = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 bottom", at_bottom, 1);
    chk("R1 max", at_max, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", ovf_irq, 0);
    chk("R1 pulse", cnt_wr_pulse, 0);
    m_cnt = 0; m_down = 0; m_flag = 0; m_pulse = 0;
    @(negedge clk);

    // R2 / R8: stopped timer ignores ticks but accepts a load
    tick_en = 1; clk_sel = 0;
    cycle(); cycle();
    chk("R2 stopped holds", count, 0);
    cnt_wr = 1; cnt_wdata = 8'hFD;
    cycle();
    chk("R8 load while stopped", count, 8'hFD);
    idle_inputs();

    // R3: wrap sets flag
    clk_sel = 3'd1; mode = 2'd0;
    cycle(); cycle();
    chk("R3 at FF", count, 8'hFF);
    chk("R9 max at FF", at_max, 1);
    cycle();
    chk("R3 wrap to 0", count, 8'h00);
    chk("R3 flag set", ovf_flag, 1);

    // R10: clear via ack, then set wins over clear
    tick_en = 0; ovf_ack = 1;
    cycle();
    chk("R10 ack clears", ovf_flag, 0);
    idle_inputs();
    cnt_wr = 1; cnt_wdata = 8'hFF;
    cycle();
    idle_inputs();
    tick_en = 1; ovf_clr = 1;
    cycle();
    chk("R10 set beats clear", ovf_flag, 1);
    idle_inputs();

    // R7: load beats a tick at FF, no flag
    ovf_clr = 1; tick_en = 0; cycle(); idle_inputs();
    cnt_wr = 1; cnt_wdata = 8'hFF; cycle();
    tick_en = 1; cnt_wr = 1; cnt_wdata = 8'h42;
    cycle();
    chk("R7 load wins", count, 8'h42);
    chk("R7 no flag", ovf_flag, 0);
    idle_inputs();

    // R4: clear on compare
    mode = 2'd1; cmp_val = 8'h45;
    repeat (5) cycle();
    chk("R4 cleared after match", count, 8'h01);

    // R6: phase-correct turnaround
    mode = 2'd3; cnt_wr = 1; cnt_wdata = 8'hFE; cycle(); idle_inputs();
    cycle(); chk("R6 reaches FF", count, 8'hFF);
    cycle(); chk("R6 turns down", count, 8'hFE);
    cnt_wr = 1; cnt_wdata = 8'h02; cycle(); idle_inputs();
    cycle(); cycle();
    chk("R6 reaches bottom", count, 8'h00);
    chk("R6 flag at bottom", ovf_flag, 1);
    cycle(); chk("R6 turns up", count, 8'h01);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) clk_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 149) == 0) cmp_val = 8'($urandom);
      tick_en   = ($urandom_range(0, 3) != 0);
      cnt_wr    = ($urandom_range(0, 63) == 0);
      cnt_wdata = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      ovf_clr   = ($urandom_range(0, 40) == 0);
      ovf_ack   = ($urandom_range(0, 40) == 0);
      ovf_ie    = ($urandom_range(0, 7) != 0);
      cycle();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule